// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches the results of page-table walks for an I/O translation unit. The array has 8 ways by 64 sets. Each entry maps a 4 KiB, 64 KiB or 1 MiB region of I/O virtual address space to a physical region. A requester presents a virtual address on the lookup port. One clock later the block returns a hit, a physical address, or a multi-hit fault. When the requester reports a miss, the walker writes its result through the fill port.

The set is always selected by address bits [17:12], which is the low end of the 4 KiB page number. This applies whatever the page size. As a result, a larger page lands in the one set picked by the address used to fill it. A lookup elsewhere in that page whose bits [17:12] differ will miss.

Software removes stale entries in two ways. A full flush empties the whole array. A per-entry invalidate acts on one set only. Covering a 64 KiB mapping therefore takes 16 invalidates, and covering a 1 MiB mapping takes up to 64. Within a set, replacement is least-recently-used.

Top module: `xlat_tlb`

## Requirements
- R1: After synchronous reset every entry is invalid and rsp_vld, rsp_hit, rsp_mhit_rd and rsp_mhit_wr are 0.
- R2: A lookup presented at clock edge N is answered at edge N+1, with rsp_vld high for exactly that cycle. The lookup sees the array as it stood before any fill, invalidate or flush taken at edge N.
- R3: fl_size encodes the page size: 0 for 4 KiB, 1 for 64 KiB, 2 for 1 MiB. An entry matches when the virtual address bits above bit 12, 16 or 20 (by its size) equal its stored tag. On a hit, rsp_pa takes its bits above that boundary from the stored physical address and its bits below from the lookup address. When rsp_hit is 0, rsp_pa is 0.
- R4: Both fill and lookup index the set with address bits [17:12]. A lookup whose bits [17:12] differ from those of the fill address misses, even when it lies inside the filled page.
- R5: When more than one way matches, rsp_hit is 0, rsp_pa is 0 and a fault is flagged. The fault goes on rsp_mhit_rd when lk_wr was 0 and on rsp_mhit_wr when lk_wr was 1.
- R6: A fill writes the lowest-numbered invalid way of its set. If no way is invalid, it writes the least-recently-used way. Recency is updated by each accepted fill and by each lookup that hits exactly one way. After reset the recency order runs from way 0 (most recent) to way 7 (least recent).
- R7: The invalidate command applies when inv_cmd bit 0 is 1. It clears every valid way in set inv_cmd[17:12] whose tag matches inv_cmd[31:12] under that entry's own size. Other sets are untouched. When bit 0 is 0 the command has no effect.
- R8: flush_all invalidates every entry.
- R9: A fill with fl_size equal to 3 is ignored.
- R10: A fill presented in the same cycle as flush_all or as a valid invalidate is dropped. When a fill is accepted, a same-cycle lookup hit does not change recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_iova | input | 32 | Lookup virtual address |
| lk_wr | input | 1 | Lookup is a write access |
| rsp_vld | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Exactly one way matched |
| rsp_pa | output | 32 | Translated physical address |
| rsp_mhit_rd | output | 1 | Multi-hit fault on a read |
| rsp_mhit_wr | output | 1 | Multi-hit fault on a write |
| fl_req | input | 1 | Fill request from the walker |
| fl_iova | input | 32 | Fill virtual address |
| fl_pa | input | 32 | Fill physical address |
| fl_size | input | 2 | Fill page size code |
| flush_all | input | 1 | Invalidate all entries |
| inv_cmd | input | 32 | Per-entry invalidate: page address with valid in bit 0 |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- **Large-page hit outside the fill set.** A 64 KiB or 1 MiB page is probed at a second address that falls in a different set. A design that indexed large pages by their own page number would report a hit where a miss is required.
- **Overlapping entries.** A 4 KiB entry is placed inside a cached 64 KiB page. A design that returned the first matching way would give a silent wrong translation instead of a read or write multi-hit fault.
- **Full set.** Nine pages are filled into one set, with a lookup touching the oldest page in between. A wrong age update would evict the touched page rather than the second-oldest.
- **Invalidate scope.** Invalidates are aimed at the wrong set, carry a clear valid bit, or hit one 1 MiB page through a set picked from its middle. A design that ignored the size mask, ignored the valid bit, or touched other sets would keep or lose the wrong entries.
- **Same-cycle collisions.** Fills collide with flushes, invalidates and lookups. A design with the wrong priority or the wrong read timing would show up there.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

  typedef enum logic [1:0] {
    SZ_SMALL = 2'd0,
    SZ_MID   = 2'd1,
    SZ_SECT  = 2'd2,
    SZ_RSVD  = 2'd3
  } pg_sz_e;

  // Number of page-number bits, above the smallest page, that a size ignores.
  function automatic int unsigned ign_bits(input logic [1:0] sz,
                                           input int unsigned mid_b,
                                           input int unsigned sect_b);
    case (sz)
      SZ_MID:  return mid_b;
      SZ_SECT: return sect_b;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/xlat_tlb_match.sv
module xlat_tlb_match #(
  parameter int unsigned WAYS   = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned MID_B  = 4,
  parameter int unsigned SECT_B = 8
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][VPN_W-1:0] vpn,
  input  logic [WAYS-1:0][1:0]       sz,
  input  logic [VPN_W-1:0]           key,
  output logic [WAYS-1:0]            hit
);
  localparam logic [VPN_W-1:0] ONE = {{(VPN_W-1){1'b0}}, 1'b1};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [VPN_W-1:0] keep;
    always_comb begin
      keep   = ~((ONE << xlat_tlb_pkg::ign_bits(sz[w], MID_B, SECT_B)) - ONE);
      hit[w] = vld[w] && (((vpn[w] ^ key) & keep) == '0);
    end
  end
endmodule

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned SETS  = 64,
  parameter int unsigned VPN_W = 20,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       inv_en,
  input  logic [IDX_W-1:0]           inv_set,
  input  logic [WAYS-1:0]            inv_kill,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_set,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [VPN_W-1:0]           wr_ppn,
  input  logic [1:0]                 wr_sz,
  input  logic [IDX_W-1:0]           a_set,
  output logic [WAYS-1:0]            a_vld,
  output logic [WAYS-1:0][VPN_W-1:0] a_vpn,
  output logic [WAYS-1:0][VPN_W-1:0] a_ppn,
  output logic [WAYS-1:0][1:0]       a_sz,
  input  logic [IDX_W-1:0]           b_set,
  output logic [WAYS-1:0]            b_vld,
  output logic [WAYS-1:0][VPN_W-1:0] b_vpn,
  output logic [WAYS-1:0][1:0]       b_sz,
  input  logic [IDX_W-1:0]           c_set,
  output logic [WAYS-1:0]            c_vld
);
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0][VPN_W-1:0] vpn_q [SETS];
  logic [WAYS-1:0][VPN_W-1:0] ppn_q [SETS];
  logic [WAYS-1:0][1:0]       sz_q  [SETS];

  // Valid bits are kept apart so flush can clear them in one cycle.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (inv_en) vld_q[inv_set] <= vld_q[inv_set] & ~inv_kill;
      if (wr_en)  vld_q[wr_set][wr_way] <= 1'b1;
    end
  end

  // Payload has no reset and one write port.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_set][wr_way] <= wr_vpn;
      ppn_q[wr_set][wr_way] <= wr_ppn;
      sz_q[wr_set][wr_way]  <= wr_sz;
    end
  end

  assign a_vld = vld_q[a_set];
  assign a_vpn = vpn_q[a_set];
  assign a_ppn = ppn_q[a_set];
  assign a_sz  = sz_q[a_set];
  assign b_vld = vld_q[b_set];
  assign b_vpn = vpn_q[b_set];
  assign b_sz  = sz_q[b_set];
  assign c_vld = vld_q[c_set];
endmodule

// File: rtl/xlat_tlb_lru.sv
module xlat_tlb_lru #(
  parameter int unsigned WAYS = 8,
  parameter int unsigned SETS = 64,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // Per-way age: 0 is most recent, WAYS-1 is least recent; each set holds a permutation.
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[rd_set][w] == OLDEST) victim = WAY_W'(w);
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned WAYS        = 8,
  parameter int unsigned SETS        = 64,
  parameter int unsigned SMALL_SHIFT = 12,
  parameter int unsigned MID_SHIFT   = 16,
  parameter int unsigned SECT_SHIFT  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_iova,
  input  logic              lk_wr,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic              rsp_mhit_rd,
  output logic              rsp_mhit_wr,
  input  logic              fl_req,
  input  logic [ADDR_W-1:0] fl_iova,
  input  logic [ADDR_W-1:0] fl_pa,
  input  logic [1:0]        fl_size,
  input  logic              flush_all,
  input  logic [ADDR_W-1:0] inv_cmd
);
  import xlat_tlb_pkg::*;

  localparam int unsigned VPN_W  = ADDR_W - SMALL_SHIFT;
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned MID_B  = MID_SHIFT - SMALL_SHIFT;
  localparam int unsigned SECT_B = SECT_SHIFT - SMALL_SHIFT;
  localparam logic [VPN_W-1:0] ONE = {{(VPN_W-1){1'b0}}, 1'b1};

  // Address fields
  logic [IDX_W-1:0] lk_set, fl_set, inv_set;
  logic [VPN_W-1:0] lk_key, inv_key;
  logic             inv_en;

  assign lk_set  = lk_iova[SMALL_SHIFT +: IDX_W];
  assign fl_set  = fl_iova[SMALL_SHIFT +: IDX_W];
  assign inv_set = inv_cmd[SMALL_SHIFT +: IDX_W];
  assign lk_key  = lk_iova[ADDR_W-1:SMALL_SHIFT];
  assign inv_key = inv_cmd[ADDR_W-1:SMALL_SHIFT];
  assign inv_en  = inv_cmd[0];

  wire unused_bits = ^{fl_iova[SMALL_SHIFT-1:0], fl_pa[SMALL_SHIFT-1:0],
                       inv_cmd[SMALL_SHIFT-1:1]};

  // Storage
  logic [WAYS-1:0]            a_vld, b_vld, c_vld, lk_hit, inv_kill;
  logic [WAYS-1:0][VPN_W-1:0] a_vpn, a_ppn, b_vpn;
  logic [WAYS-1:0][1:0]       a_sz, b_sz;
  logic                       fill_go;
  logic [WAY_W-1:0]           fill_way, lru_way, free_way, hit_way;

  xlat_tlb_store #(.WAYS(WAYS), .SETS(SETS), .VPN_W(VPN_W)) store_i (
    .clk(clk), .rst(rst), .flush(flush_all),
    .inv_en(inv_en), .inv_set(inv_set), .inv_kill(inv_kill),
    .wr_en(fill_go), .wr_set(fl_set), .wr_way(fill_way),
    .wr_vpn(fl_iova[ADDR_W-1:SMALL_SHIFT]), .wr_ppn(fl_pa[ADDR_W-1:SMALL_SHIFT]),
    .wr_sz(fl_size),
    .a_set(lk_set), .a_vld(a_vld), .a_vpn(a_vpn), .a_ppn(a_ppn), .a_sz(a_sz),
    .b_set(inv_set), .b_vld(b_vld), .b_vpn(b_vpn), .b_sz(b_sz),
    .c_set(fl_set), .c_vld(c_vld)
  );

  xlat_tlb_match #(.WAYS(WAYS), .VPN_W(VPN_W), .MID_B(MID_B), .SECT_B(SECT_B)) lk_match_i (
    .vld(a_vld), .vpn(a_vpn), .sz(a_sz), .key(lk_key), .hit(lk_hit)
  );

  xlat_tlb_match #(.WAYS(WAYS), .VPN_W(VPN_W), .MID_B(MID_B), .SECT_B(SECT_B)) inv_match_i (
    .vld(b_vld), .vpn(b_vpn), .sz(b_sz), .key(inv_key), .hit(inv_kill)
  );

  // Lookup resolution
  logic             one_hit, many_hit;
  logic [VPN_W-1:0] keep, pa_pn;

  assign one_hit  = ($countones(lk_hit) == 1);
  assign many_hit = ($countones(lk_hit) > 1);

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (lk_hit[w]) hit_way = WAY_W'(w);
  end

  always_comb begin
    keep  = ~((ONE << ign_bits(a_sz[hit_way], MID_B, SECT_B)) - ONE);
    pa_pn = (a_ppn[hit_way] & keep) | (lk_key & ~keep);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld     <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_pa      <= '0;
      rsp_mhit_rd <= 1'b0;
      rsp_mhit_wr <= 1'b0;
    end else begin
      rsp_vld     <= lk_req;
      rsp_hit     <= lk_req && one_hit;
      rsp_pa      <= (lk_req && one_hit) ? {pa_pn, lk_iova[SMALL_SHIFT-1:0]} : '0;
      rsp_mhit_rd <= lk_req && many_hit && !lk_wr;
      rsp_mhit_wr <= lk_req && many_hit && lk_wr;
    end
  end

  // Fill placement
  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!c_vld[w]) free_way = WAY_W'(w);
  end

  assign fill_go  = fl_req && (fl_size != SZ_RSVD) && !flush_all && !inv_en;
  assign fill_way = (&c_vld) ? lru_way : free_way;

  xlat_tlb_lru #(.WAYS(WAYS), .SETS(SETS)) lru_i (
    .clk(clk), .rst(rst),
    .touch_en(fill_go || (lk_req && one_hit)),
    .touch_set(fill_go ? fl_set : lk_set),
    .touch_way(fill_go ? fill_way : hit_way),
    .rd_set(fl_set), .victim(lru_way)
  );
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_req,
  input logic [ADDR_W-1:0] lk_iova,
  input logic              lk_wr,
  input logic              rsp_vld,
  input logic              rsp_hit,
  input logic [ADDR_W-1:0] rsp_pa,
  input logic              rsp_mhit_rd,
  input logic              rsp_mhit_wr,
  input logic              flush_all
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !rsp_vld && !rsp_hit && !rsp_mhit_rd && !rsp_mhit_wr); // R1
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst) lk_req |=> rsp_vld); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst) !lk_req |=> !rsp_vld); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !rsp_vld |-> !rsp_hit && !rsp_mhit_rd && !rsp_mhit_wr); // R2
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (rst) lk_req ##1 rsp_hit |-> rsp_pa[11:0] == $past(lk_iova[11:0])); // R3
  AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (rst) !rsp_hit |-> rsp_pa == '0); // R3
  AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({rsp_hit, rsp_mhit_rd, rsp_mhit_wr})); // R5
  AST_MHIT_RD_DIR: assert property (@(posedge clk) disable iff (rst) lk_req && !lk_wr |=> !rsp_mhit_wr); // R5
  AST_MHIT_WR_DIR: assert property (@(posedge clk) disable iff (rst) lk_req && lk_wr |=> !rsp_mhit_rd); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst) flush_all ##1 lk_req |=> !rsp_hit && !rsp_mhit_rd && !rsp_mhit_wr); // R8
endmodule

bind xlat_tlb xlat_tlb_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .lk_req(lk_req), .lk_iova(lk_iova), .lk_wr(lk_wr),
  .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
  .rsp_mhit_rd(rsp_mhit_rd), .rsp_mhit_wr(rsp_mhit_wr), .flush_all(flush_all)
);

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
  localparam int NSETS = 64;
  localparam int NWAYS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0, lk_wr = 1'b0;
  logic [31:0] lk_iova = '0;
  logic        rsp_vld, rsp_hit, rsp_mhit_rd, rsp_mhit_wr;
  logic [31:0] rsp_pa;
  logic        fl_req = 1'b0;
  logic [31:0] fl_iova = '0, fl_pa = '0;
  logic [1:0]  fl_size = '0;
  logic        flush_all = 1'b0;
  logic [31:0] inv_cmd = '0;

  always #4 clk = ~clk;

  xlat_tlb dut_i (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_iova(lk_iova), .lk_wr(lk_wr),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
    .rsp_mhit_rd(rsp_mhit_rd), .rsp_mhit_wr(rsp_mhit_wr),
    .fl_req(fl_req), .fl_iova(fl_iova), .fl_pa(fl_pa), .fl_size(fl_size),
    .flush_all(flush_all), .inv_cmd(inv_cmd)
  );

  int    checks = 0, errors = 0, cyc = 0;
  bit    started = 0;
  string tag = "R1";

  // Behavioural reference model
  bit          m_vld [NSETS][NWAYS];
  int unsigned m_vpn [NSETS][NWAYS];
  int unsigned m_ppn [NSETS][NWAYS];
  int          m_sz  [NSETS][NWAYS];
  int          lru_q [NSETS][$];
  bit          e_vld, e_hit, e_mr, e_mw;
  logic [31:0] e_pa;

  function automatic int ign_of(int sz);
    return (sz == 1) ? 4 : ((sz == 2) ? 8 : 0);
  endfunction

  function automatic bit covers(int unsigned vpn, int sz, int unsigned key);
    return ((vpn ^ key) >> ign_of(sz)) == 0;
  endfunction

  task automatic touch(int s, int w);
    foreach (lru_q[s][i]) if (lru_q[s][i] == w) begin lru_q[s].delete(i); break; end
    lru_q[s].push_front(w);
  endtask

  always @(posedge clk) begin : model
    int s, n, hw, fs, vw, ign;
    int unsigned key;
    bit take;
    if (rst) begin
      for (int i = 0; i < NSETS; i++) begin
        lru_q[i].delete();
        for (int w = 0; w < NWAYS; w++) begin m_vld[i][w] = 0; lru_q[i].push_back(w); end
      end
      e_vld = 0; e_hit = 0; e_mr = 0; e_mw = 0; e_pa = '0;
    end else begin
      e_vld = lk_req; e_hit = 0; e_mr = 0; e_mw = 0; e_pa = '0;
      n = 0; hw = 0;
      s = int'((lk_iova >> 12) & 32'h3F);
      key = lk_iova >> 12;
      if (lk_req) begin
        for (int w = 0; w < NWAYS; w++)
          if (m_vld[s][w] && covers(m_vpn[s][w], m_sz[s][w], key)) begin n++; hw = w; end
        if (n == 1) begin
          ign = ign_of(m_sz[s][hw]);
          e_hit = 1;
          e_pa = {((m_ppn[s][hw] >> ign) << ign) | (key & ((32'd1 << ign) - 1)), 12'h000} | (lk_iova & 32'hFFF);
        end else if (n > 1) begin
          e_mr = !lk_wr; e_mw = lk_wr;
        end
      end
      take = fl_req && fl_size != 2'd3 && !flush_all && !inv_cmd[0];
      if (flush_all) begin
        for (int i = 0; i < NSETS; i++) for (int w = 0; w < NWAYS; w++) m_vld[i][w] = 0;
      end else if (inv_cmd[0]) begin
        fs = int'((inv_cmd >> 12) & 32'h3F);
        for (int w = 0; w < NWAYS; w++)
          if (m_vld[fs][w] && covers(m_vpn[fs][w], m_sz[fs][w], inv_cmd >> 12)) m_vld[fs][w] = 0;
      end
      if (take) begin
        fs = int'((fl_iova >> 12) & 32'h3F);
        vw = -1;
        for (int w = 0; w < NWAYS; w++) if (!m_vld[fs][w] && vw < 0) vw = w;
        if (vw < 0) vw = lru_q[fs][$];
        m_vld[fs][vw] = 1; m_vpn[fs][vw] = fl_iova >> 12;
        m_ppn[fs][vw] = fl_pa >> 12; m_sz[fs][vw] = int'(fl_size);
        touch(fs, vw);
      end else if (lk_req && n == 1) begin
        touch(s, hw);
      end
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rsp_vld !== e_vld || rsp_hit !== e_hit || rsp_pa !== e_pa ||
          rsp_mhit_rd !== e_mr || rsp_mhit_wr !== e_mw) begin
        errors++;
        $display("FAIL %s model: got vld=%0b hit=%0b pa=%h mr=%0b mw=%0b exp vld=%0b hit=%0b pa=%h mr=%0b mw=%0b",
                 tag, rsp_vld, rsp_hit, rsp_pa, rsp_mhit_rd, rsp_mhit_wr, e_vld, e_hit, e_pa, e_mr, e_mw);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic expect_rsp(string t, bit hit, logic [31:0] pa, bit mr, bit mw);
    checks++;
    if (rsp_vld !== 1'b1 || rsp_hit !== hit || rsp_pa !== pa || rsp_mhit_rd !== mr || rsp_mhit_wr !== mw) begin
      errors++;
      $display("FAIL %s: got hit=%0b pa=%h mr=%0b mw=%0b exp hit=%0b pa=%h mr=%0b mw=%0b",
               t, rsp_hit, rsp_pa, rsp_mhit_rd, rsp_mhit_wr, hit, pa, mr, mw);
    end
  endtask

  task automatic lookup(logic [31:0] a, bit wr);
    lk_req = 1; lk_iova = a; lk_wr = wr;
    @(negedge clk);
    lk_req = 0; lk_wr = 0;
  endtask

  task automatic fill(logic [31:0] a, logic [31:0] p, logic [1:0] sz);
    fl_req = 1; fl_iova = a; fl_pa = p; fl_size = sz;
    @(negedge clk);
    fl_req = 0;
  endtask

  task automatic inval(logic [31:0] c);
    inv_cmd = c;
    @(negedge clk);
    inv_cmd = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (rsp_vld !== 0 || rsp_hit !== 0 || rsp_mhit_rd !== 0 || rsp_mhit_wr !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs: got vld=%0b hit=%0b exp 0 0", rsp_vld, rsp_hit);
    end
    started = 1;
    tag = "R1"; lookup(32'h0000_3ABC, 0); expect_rsp("R1 empty after reset", 0, 0, 0, 0);

    tag = "R3";
    fill(32'h0000_3000, 32'h8765_4000, 2'd0);
    lookup(32'h0000_3ABC, 0); expect_rsp("R3 4K hit", 1, 32'h8765_4ABC, 0, 0);
    lookup(32'h0000_4ABC, 0); expect_rsp("R3 4K neighbour miss", 0, 0, 0, 0);
    fill(32'h0012_5000, 32'h4000_0000, 2'd1);
    lookup(32'h0012_5123, 0); expect_rsp("R3 64K hit", 1, 32'h4000_5123, 0, 0);
    fill(32'h0302_A000, 32'h9000_0000, 2'd2);
    lookup(32'h030E_A456, 1); expect_rsp("R4 1M hit via same set", 1, 32'h900E_A456, 0, 0);
    tag = "R4";
    lookup(32'h0012_6123, 0); expect_rsp("R4 64K other set miss", 0, 0, 0, 0);
    lookup(32'h0308_A000, 0); expect_rsp("R4 1M other set miss", 0, 0, 0, 0);

    tag = "R5";
    fill(32'h0012_5000, 32'h1111_1000, 2'd0);
    lookup(32'h0012_5010, 0); expect_rsp("R5 multi-hit read", 0, 0, 1, 0);
    lookup(32'h0012_5010, 1); expect_rsp("R5 multi-hit write", 0, 0, 0, 1);

    tag = "R7";
    inval(32'h0012_5001);
    lookup(32'h0012_5010, 0); expect_rsp("R7 both overlapping entries cleared", 0, 0, 0, 0);
    inval(32'h0302_A000);
    lookup(32'h0302_A000, 0); expect_rsp("R7 valid bit clear ignored", 1, 32'h9002_A000, 0, 0);
    inval(32'h0300_0001);
    lookup(32'h0302_A000, 0); expect_rsp("R7 other set untouched", 1, 32'h9002_A000, 0, 0);
    inval(32'h030E_A001);
    lookup(32'h0302_A000, 0); expect_rsp("R7 1M cleared through its set", 0, 0, 0, 0);

    tag = "R6";
    for (int k = 1; k <= 8; k++) fill((k << 18) | (9 << 12), k << 24, 2'd0);
    lookup((1 << 18) | (9 << 12) | 32'h44, 0); expect_rsp("R6 oldest touched", 1, (1 << 24) | 32'h44, 0, 0);
    fill((9 << 18) | (9 << 12), 9 << 24, 2'd0);
    lookup((2 << 18) | (9 << 12) | 32'h44, 0); expect_rsp("R6 LRU evicted", 0, 0, 0, 0);
    lookup((1 << 18) | (9 << 12) | 32'h44, 0); expect_rsp("R6 touched kept", 1, (1 << 24) | 32'h44, 0, 0);
    lookup((9 << 18) | (9 << 12) | 32'h44, 0); expect_rsp("R6 new fill present", 1, (9 << 24) | 32'h44, 0, 0);

    tag = "R8";
    flush_all = 1; @(negedge clk); flush_all = 0;
    lookup(32'h0000_3ABC, 0); expect_rsp("R8 flushed", 0, 0, 0, 0);

    tag = "R9";
    fill(32'h0000_7000, 32'h2222_2000, 2'd3);
    lookup(32'h0000_7000, 0); expect_rsp("R9 reserved size dropped", 0, 0, 0, 0);

    tag = "R10";
    fl_req = 1; fl_iova = 32'h0000_8000; fl_pa = 32'h3333_3000; fl_size = 2'd0; flush_all = 1;
    @(negedge clk); fl_req = 0; flush_all = 0;
    lookup(32'h0000_8000, 0); expect_rsp("R10 fill dropped by flush", 0, 0, 0, 0);
    fl_req = 1; inv_cmd = 32'h0040_0001;
    @(negedge clk); fl_req = 0; inv_cmd = '0;
    lookup(32'h0000_8000, 0); expect_rsp("R10 fill dropped by invalidate", 0, 0, 0, 0);
    tag = "R2";
    fl_req = 1; lk_req = 1; lk_iova = 32'h0000_8010;
    @(negedge clk); fl_req = 0; lk_req = 0;
    expect_rsp("R2 same-cycle fill unseen", 0, 0, 0, 0);
    lookup(32'h0000_8010, 0); expect_rsp("R2 next lookup hits", 1, 32'h3333_3010, 0, 0);

    tag = "R6 R7 R10 mix";
    for (int i = 0; i < 3000; i++) begin
      lk_req   = ($urandom % 2) == 0;
      lk_wr    = $urandom % 2;
      lk_iova  = (($urandom % 4) << 20) | (($urandom % 4) << 16) | (($urandom % 3) << 12) | ($urandom % 4096);
      fl_req   = ($urandom % 3) == 0;
      fl_iova  = (($urandom % 4) << 20) | (($urandom % 4) << 16) | (($urandom % 3) << 12);
      fl_pa    = $urandom & 32'hFFFF_F000;
      fl_size  = 2'($urandom % 4);
      inv_cmd  = (($urandom % 4) << 20) | (($urandom % 4) << 16) | (($urandom % 3) << 12) | 32'(($urandom % 8) == 0);
      flush_all = ($urandom % 200) == 0;
      @(negedge clk);
    end
    lk_req = 0; fl_req = 0; inv_cmd = '0; flush_all = 0;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule